// File: doc/BRIEF.md
# Receive Frame Queue with Overflow Drop

This block sits between a receive byte stream and the host side of a network receiver. When no host receive descriptor is available, complete incoming frames are parked in an on-chip word memory and later released, oldest first, once descriptor polling reports an owned descriptor. Every frame goes into the memory behind a length word that gives its byte count. A frame's bytes leave the block exactly as they arrived, marked with start and end flags.

The usable capacity comes from a size input, in memory words, clamped to the built depth. A frame that does not fit is removed in full, so a partial frame never reaches the output. After any overflow the block enters a drop state. In that state it discards every arriving frame until the memory has fully drained, even if space frees up earlier. A size of zero turns queuing off, and beats then pass through one register stage with the descriptor input ignored.

Top module: `rx_frame_queue`

## Requirements
- R1: With `cfg_size` = 0, each input beat (valid, data, start, end) appears on the outputs unchanged exactly one clock later, whatever `desc_avail` is.
- R2: With `cfg_size` != 0, stored frames produce no output beat while `desc_avail` is low.
- R3: Frames leave whole and in arrival order with bytes unchanged. `out_sof` marks the first byte, `out_eof` marks the last, and neither flag is ever high without `out_valid`.
- R4: In queuing mode an output beat appears only in the clock after a cycle with `desc_avail` high. A low `desc_avail` pauses a frame mid-way without losing or repeating bytes.
- R5: Capacity is min(`cfg_size`, DEPTH) words, and an n-byte frame takes n+1 words (length word plus data). A frame is kept only if it fits in full on arrival, occupancy never exceeds capacity, and a frame that does not fit is discarded entirely.
- R6: After an overflow, every frame is discarded until the memory is empty. The first frame whose start beat arrives when the memory is empty is accepted again.
- R7: A start beat inside an open frame discards the partial frame, and the new frame is stored in its place.
- R8: Input beats without a start flag that arrive outside a frame are ignored.
- R9: During and after reset `out_valid` is low and the memory is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_size | input | LEN_W | Usable memory size in words; 0 selects pass-through |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Input beat is the first byte of a frame |
| in_eof | input | 1 | Input beat is the last byte of a frame |
| in_data | input | 8 | Input byte |
| desc_avail | input | 1 | A host receive descriptor is owned; release allowed |
| out_valid | output | 1 | Output beat valid |
| out_sof | output | 1 | Output beat is the first byte of a frame |
| out_eof | output | 1 | Output beat is the last byte of a frame |
| out_data | output | 8 | Output byte |

## Verification
The hardest case to reach is a frame that arrives after an overflow while the memory is part-way drained. Space is free at that moment, yet the frame must still be dropped. The stimulus fills the memory with two frames, overflows it with a third, and then raises `desc_avail` for a fixed number of cycles so that part of the second frame is still waiting. A short frame is sent at that moment and must vanish, while a frame sent after the drain completes must come out. Exact-fit and one-word-over frames at several sizes, including a size above the built depth, cover the capacity boundary.

// File: rtl/rfq_pkg.sv
package rfq_pkg;

    typedef enum logic [0:0] {
        RD_IDLE = 1'b0,
        RD_DATA = 1'b1
    } rd_state_e;

endpackage

// File: rtl/rfq_mem.sv
module rfq_mem #(
    parameter int DEPTH  = 32,
    parameter int WORD_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic [PTR_W-1:0]  a_addr,
    input  logic [WORD_W-1:0] a_data,
    input  logic              b_en,
    input  logic [PTR_W-1:0]  b_addr,
    input  logic [WORD_W-1:0] b_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] store [DEPTH];

    // Port a carries frame bytes, port b the length word; addresses never collide.
    always_ff @(posedge clk) begin
        if (a_en) store[a_addr] <= a_data;
        if (b_en) store[b_addr] <= b_data;
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/rfq_wr.sv
module rfq_wr #(
    parameter int DEPTH   = 32,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int LEN_W  = PTR_W + 1,
    localparam int WORD_W = (LEN_W > 8) ? LEN_W : 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LEN_W-1:0]  cap,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic              pop,
    output logic [LEN_W-1:0]  used,
    output logic              dw_en,
    output logic [PTR_W-1:0]  dw_addr,
    output logic [WORD_W-1:0] dw_data,
    output logic              hw_en,
    output logic [PTR_W-1:0]  hw_addr,
    output logic [WORD_W-1:0] hw_data
);

    typedef struct packed {
        logic [PTR_W-1:0] commit;   // slot of the next frame's length word
        logic [PTR_W-1:0] wptr;     // next data slot of the open frame
        logic [LEN_W-1:0] nbytes;   // bytes taken so far in the open frame
        logic [LEN_W-1:0] used;     // committed words not yet read
        logic             open;
        logic             drop;
    } wr_state_t;

    wr_state_t q, d;

    logic             take_start;
    logic             take_cont;
    logic [LEN_W-1:0] new_len;
    logic [LEN_W:0]   need;
    logic [PTR_W-1:0] slot;

    always_comb begin
        d       = q;
        dw_en   = 1'b0;
        hw_en   = 1'b0;
        hw_addr = q.commit;
        dw_data = WORD_W'(in_data);
        slot    = in_sof ? q.commit + PTR_W'(1) : q.wptr;
        dw_addr = slot;
        new_len = in_sof ? LEN_W'(1) : q.nbytes + LEN_W'(1);
        hw_data = WORD_W'(new_len);
        need    = {1'b0, q.used} + {1'b0, new_len} + (LEN_W+1)'(1);

        d.used = q.used - LEN_W'(pop);

        take_start = in_valid && in_sof && (!q.drop || q.used == '0);
        take_cont  = in_valid && !in_sof && q.open;

        if (in_valid && in_sof && !take_start) begin
            d.open = 1'b0;
        end

        if (take_start || take_cont) begin
            if (need > {1'b0, cap}) begin
                // no room: roll the open frame back and enter the drop state
                d.open   = 1'b0;
                d.nbytes = '0;
                d.drop   = 1'b1;
            end else begin
                dw_en    = 1'b1;
                d.wptr   = slot + PTR_W'(1);
                d.nbytes = new_len;
                d.open   = 1'b1;
                if (take_start) d.drop = 1'b0;
                if (in_eof) begin
                    hw_en    = 1'b1;
                    d.commit = slot + PTR_W'(1);
                    d.used   = q.used - LEN_W'(pop) + new_len + LEN_W'(1);
                    d.open   = 1'b0;
                end
            end
        end

        if (!en) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign used = q.used;

endmodule

// File: rtl/rfq_rd.sv
module rfq_rd
    import rfq_pkg::*;
#(
    parameter int DEPTH   = 32,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int LEN_W  = PTR_W + 1,
    localparam int WORD_W = (LEN_W > 8) ? LEN_W : 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [LEN_W-1:0]  used,
    input  logic              desc_avail,
    input  logic [WORD_W-1:0] rd_word,
    output logic [PTR_W-1:0]  rd_addr,
    output logic              pop,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic [7:0]        out_data
);

    typedef struct packed {
        rd_state_e        st;
        logic [PTR_W-1:0] ptr;
        logic [LEN_W-1:0] left;
        logic             first;
        logic             ov;
        logic             osof;
        logic             oeof;
        logic [7:0]       odata;
    } rd_reg_t;

    rd_reg_t q, d;

    always_comb begin
        d      = q;
        pop    = 1'b0;
        d.ov   = 1'b0;
        d.osof = 1'b0;
        d.oeof = 1'b0;

        unique case (q.st)
            RD_IDLE: begin
                if (desc_avail && used != '0) begin
                    pop     = 1'b1;
                    d.left  = rd_word[LEN_W-1:0];
                    d.ptr   = q.ptr + PTR_W'(1);
                    d.first = 1'b1;
                    d.st    = RD_DATA;
                end
            end
            RD_DATA: begin
                if (desc_avail) begin
                    pop     = 1'b1;
                    d.ov    = 1'b1;
                    d.odata = rd_word[7:0];
                    d.osof  = q.first;
                    d.oeof  = (q.left == LEN_W'(1));
                    d.first = 1'b0;
                    d.left  = q.left - LEN_W'(1);
                    d.ptr   = q.ptr + PTR_W'(1);
                    if (q.left == LEN_W'(1)) d.st = RD_IDLE;
                end
            end
            default: d.st = RD_IDLE;
        endcase

        if (!en) begin
            d   = '0;
            pop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr   = q.ptr;
    assign out_valid = q.ov;
    assign out_sof   = q.osof;
    assign out_eof   = q.oeof;
    assign out_data  = q.odata;

endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue #(
    parameter int DEPTH   = 32,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int LEN_W  = PTR_W + 1,
    localparam int WORD_W = (LEN_W > 8) ? LEN_W : 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_size,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [7:0]       in_data,
    input  logic             desc_avail,
    output logic             out_valid,
    output logic             out_sof,
    output logic             out_eof,
    output logic [7:0]       out_data
);

    typedef struct packed {
        logic       v;
        logic       s;
        logic       e;
        logic [7:0] b;
    } pass_t;

    pass_t pass_q, pass_d;

    logic              queue_en;
    logic [LEN_W-1:0]  cap_w;
    logic [LEN_W-1:0]  used_w;
    logic              pop_w;
    logic              dw_en, hw_en;
    logic [PTR_W-1:0]  dw_addr, hw_addr, rd_addr;
    logic [WORD_W-1:0] dw_data, hw_data, rd_word;
    logic              q_valid, q_sof, q_eof;
    logic [7:0]        q_data;

    assign queue_en = (cfg_size != '0);
    assign cap_w    = (cfg_size > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : cfg_size;

    always_comb begin
        pass_d = '0;
        if (!queue_en) begin
            pass_d.v = in_valid;
            pass_d.s = in_sof;
            pass_d.e = in_eof;
            pass_d.b = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pass_q <= '0;
        else        pass_q <= pass_d;
    end

    rfq_wr #(.DEPTH(DEPTH)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (queue_en),
        .cap      (cap_w),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_data  (in_data),
        .pop      (pop_w),
        .used     (used_w),
        .dw_en    (dw_en),
        .dw_addr  (dw_addr),
        .dw_data  (dw_data),
        .hw_en    (hw_en),
        .hw_addr  (hw_addr),
        .hw_data  (hw_data)
    );

    rfq_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
        .clk     (clk),
        .a_en    (dw_en),
        .a_addr  (dw_addr),
        .a_data  (dw_data),
        .b_en    (hw_en),
        .b_addr  (hw_addr),
        .b_data  (hw_data),
        .rd_addr (rd_addr),
        .rd_data (rd_word)
    );

    rfq_rd #(.DEPTH(DEPTH)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (queue_en),
        .used       (used_w),
        .desc_avail (desc_avail),
        .rd_word    (rd_word),
        .rd_addr    (rd_addr),
        .pop        (pop_w),
        .out_valid  (q_valid),
        .out_sof    (q_sof),
        .out_eof    (q_eof),
        .out_data   (q_data)
    );

    assign out_valid = queue_en ? q_valid : pass_q.v;
    assign out_sof   = queue_en ? q_sof   : pass_q.s;
    assign out_eof   = queue_en ? q_eof   : pass_q.e;
    assign out_data  = queue_en ? q_data  : pass_q.b;

endmodule

// File: rtl/rfq_chk.sv
module rfq_chk #(
    parameter int LEN_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             queue_en,
    input logic [LEN_W-1:0] cap,
    input logic [LEN_W-1:0] used,
    input logic             desc_avail,
    input logic             in_valid,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_eof
);

    logic in_out_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         in_out_frame <= 1'b0;
        else if (out_valid) in_out_frame <= !out_eof;
    end

    assert_flags_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_sof && !out_eof));

    assert_open_sof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_out_frame) |-> out_sof);

    assert_no_double_sof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sof) |-> !in_out_frame);

    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (queue_en && out_valid) |-> $past(desc_avail));

    assert_occupancy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        queue_en |-> (used <= cap));

    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!queue_en && $past(!queue_en) && $past(rst_n)) |-> (out_valid == $past(in_valid)));

endmodule

bind rx_frame_queue rfq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .queue_en   (queue_en),
    .cap        (cap_w),
    .used       (used_w),
    .desc_avail (desc_avail),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_eof    (out_eof)
);

// File: tb/tb_rx_frame_queue.sv
`timescale 1ns/1ps
module tb_rx_frame_queue;

    localparam int DEPTH = 32;
    localparam int LEN_W = $clog2(DEPTH) + 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LEN_W-1:0] cfg_size;
    logic             in_valid, in_sof, in_eof;
    logic [7:0]       in_data;
    logic             desc_avail;
    logic             out_valid, out_sof, out_eof;
    logic [7:0]       out_data;

    always #5 clk = ~clk;

    rx_frame_queue #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .desc_avail(desc_avail),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data)
    );

    int tests = 0;
    int fails = 0;
    byte unsigned got_q[$];
    byte unsigned exp_q[$];
    int n_sof = 0, exp_frames = 0, frame_err = 0, gate_err = 0;
    bit open_frame = 0;

    // entry: {cfg, length, seed, kept}
    localparam logic [24:0] VECS [10] = '{
        {8'd32, 8'd5,  8'h10, 1'b1},   // R3 basic frame
        {8'd32, 8'd31, 8'h20, 1'b1},   // R5 exact fit: 32 words
        {8'd32, 8'd32, 8'h30, 1'b0},   // R5 one word over
        {8'd10, 8'd9,  8'h40, 1'b1},   // R5 exact fit at small size
        {8'd10, 8'd10, 8'h50, 1'b0},   // R5 over at small size
        {8'd40, 8'd31, 8'h60, 1'b1},   // R5 size clamped to depth
        {8'd40, 8'd32, 8'h70, 1'b0},   // R5 clamped, over
        {8'd0,  8'd6,  8'h80, 1'b1},   // R1 pass-through
        {8'd1,  8'd1,  8'h90, 1'b0},   // R5 one-byte frame needs two words
        {8'd2,  8'd1,  8'hA0, 1'b1}    // R5 one-byte frame fits exactly
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // output monitor, sampled 1 ns after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (rst_n && out_valid) begin
            if (out_sof == open_frame) frame_err++;
            if (cfg_size != '0 && !desc_avail) gate_err++;
            got_q.push_back(out_data);
            if (out_sof) n_sof++;
            open_frame = !out_eof;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input int seed, input bit kept);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_data  = 8'(seed + 3 * i);
            if (kept) exp_q.push_back(8'(seed + 3 * i));
        end
        if (kept) exp_frames++;
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic compare(input string req);
        int bad = 0;
        check(got_q.size() == exp_q.size(), req, "byte count", got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size())
            foreach (exp_q[i]) if (got_q[i] != exp_q[i]) bad++;
        check(bad == 0, req, "mismatching bytes", bad, 0);
        check(n_sof == exp_frames, req, "frame count", n_sof, exp_frames);
        check(frame_err == 0, "R3", "frame marker errors", frame_err, 0);
        got_q.delete(); exp_q.delete();
        n_sof = 0; exp_frames = 0; frame_err = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_size = LEN_W'(32);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
        desc_avail = 1'b0;
        idle(3);
        check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        desc_avail = 1'b1;
        idle(6);
        check(got_q.size() == 0, "R9", "output after reset with empty queue", got_q.size(), 0);
        desc_avail = 1'b0;

        // vector walk: R2, R3, R5, R1
        for (int v = 0; v < 10; v++) begin
            cfg_size = LEN_W'(VECS[v][24:17]);
            idle(2);
            send_frame(int'(VECS[v][16:9]), int'(VECS[v][8:1]), VECS[v][0]);
            idle(5);
            if (cfg_size != '0)
                check(got_q.size() == 0, "R2", "output while descriptor absent", got_q.size(), 0);
            desc_avail = 1'b1;
            idle(int'(VECS[v][16:9]) + 10);
            desc_avail = 1'b0;
            compare(VECS[v][24:17] == 8'd0 ? "R1" : "R5");
        end

        // R1: one-clock latency, descriptor ignored
        cfg_size = '0;
        idle(2);
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'h5A;
        @(posedge clk); #1;
        check(out_valid && out_sof && out_eof && out_data == 8'h5A, "R1",
              "pass-through beat one clock later", int'(out_data), 8'h5A);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        idle(2);
        got_q.delete(); n_sof = 0;

        // R2 + R3: two frames held, then released in order
        cfg_size = LEN_W'(32);
        idle(2);
        send_frame(4, 8'h11, 1'b1);
        send_frame(7, 8'hC3, 1'b1);
        idle(10);
        check(got_q.size() == 0, "R2", "two frames held", got_q.size(), 0);
        desc_avail = 1'b1;
        idle(25);
        desc_avail = 1'b0;
        compare("R3");

        // R4: descriptor toggling pauses the frame
        send_frame(12, 8'h33, 1'b1);
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            desc_avail = (i % 3) != 0;
        end
        desc_avail = 1'b1;
        idle(10);
        desc_avail = 1'b0;
        check(gate_err == 0, "R4", "beats without descriptor", gate_err, 0);
        compare("R4");

        // R6: drop until empty, even once space has been freed
        cfg_size = LEN_W'(20);
        idle(2);
        send_frame(8, 8'h01, 1'b1);     // 9 words
        send_frame(8, 8'h41, 1'b1);     // 18 words
        send_frame(8, 8'h81, 1'b0);     // overflows on its second byte
        send_frame(1, 8'hE1, 1'b0);     // drop state, queue not empty
        desc_avail = 1'b1;
        idle(12);                       // second frame still part-way out
        send_frame(2, 8'hF1, 1'b0);     // space free but not yet empty
        idle(25);
        send_frame(3, 8'h71, 1'b1);     // empty now: accepted
        idle(12);
        desc_avail = 1'b0;
        compare("R6");

        // R8: stray beats outside a frame
        cfg_size = LEN_W'(32);
        idle(2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 2); in_data = 8'hEE;
        end
        send_frame(2, 8'h21, 1'b1);
        desc_avail = 1'b1;
        idle(10);
        desc_avail = 1'b0;
        compare("R8");

        // R7: restart inside an open frame
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sof = (i == 0); in_eof = 1'b0; in_data = 8'hDD;
        end
        send_frame(4, 8'h61, 1'b1);
        desc_avail = 1'b1;
        idle(10);
        desc_avail = 1'b0;
        compare("R7");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule